// File: doc/BRIEF.md
# Register-Mapped Interrupt Request Aggregator

This block gathers a parameterised number of interrupt sources (up to 32) into one request line for a processor or for a controller one level up. Each source is latched into a sticky status bit, either on a rising edge or whenever it is seen high. A build-time mask picks the sensing mode per source. A per-source enable gates the latched bits. The result goes through a two-bit global gate before it drives the single request output.

Software reaches the block through a plain word-wide register port. A write strobe, a byte offset and write data go in, and read data comes back in the same cycle. Enables can be changed atomically through separate set and clear offsets. Sources are acknowledged by writing ones. A vector offset returns the lowest-numbered source that is both latched and enabled, or all ones when there is none.

Top module: `irqc_top`

## Requirements
- R1: After reset the status (0x00), enable (0x08) and master (0x1C) registers read 0, the request output is low, and reads of the acknowledge (0x0C), set-enable (0x10) and clear-enable (0x14) offsets return 0.
- R2: A level-sensitive source (EDGE_MASK bit 0) sets its status bit on every clock edge at which it is high, so an acknowledge issued while it is still high leaves the bit set.
- R3: An edge-sensitive source (EDGE_MASK bit 1) sets its status bit only on a low-to-high transition; holding it high after an acknowledge leaves the bit clear.
- R4: A write to offset 0x0C clears every status bit written as one and leaves all other status bits unchanged; writing 0xFFFFFFFF clears them all.
- R5: A write to 0x08 loads the enable register, and writing 0 disables all sources. A write to 0x10 ORs its data into the enables. A write to 0x14 clears the enables written as one.
- R6: Offset 0x04 reads status AND enable; the status register itself is unaffected by the enables.
- R7: Offset 0x18 reads the index of the lowest-numbered bit set in the 0x04 value, or 0xFFFFFFFF when that value is zero.
- R8: Offset 0x1C stores and reads back bits [1:0] (bit 0 global enable, bit 1 request-line enable). irq_out is high exactly when the 0x04 value is non-zero and both bits are 1.
- R9: Status and enable bits at and above NUM_SRC read as 0, and EDGE_MASK bits at and above NUM_SRC have no effect.
- R10: Writes to offsets 0x00, 0x04 and 0x18 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Interrupt source lines |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte offset of the register; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Request to the processor or the parent controller |

## Verification
The bench builds the block with NUM_SRC = 8 and EDGE_MASK = 0xFFFFFFF0. Sources 0 to 3 are therefore level-sensitive and sources 4 to 7 edge-sensitive, so one run covers both sensing modes, including a mix of them in one pattern. Because the width is narrow, bits 8 to 31 of the enable write data and of EDGE_MASK fall outside the implemented range. The bench can then confirm at the read port that they are dropped.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 5;

    // Word index (bus_addr[4:2]) of each register.
    typedef enum logic [2:0] {
        SEL_STAT  = 3'd0,
        SEL_PEND  = 3'd1,
        SEL_EN    = 3'd2,
        SEL_ACK   = 3'd3,
        SEL_SETEN = 3'd4,
        SEL_CLREN = 3'd5,
        SEL_VEC   = 3'd6,
        SEL_MER   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic req_en;   // bit 1
        logic glb_en;   // bit 0
    } mer_t;

    typedef struct packed {
        logic              ack;
        logic              en_ld;
        logic              en_set;
        logic              en_clr;
        logic              mer_ld;
        logic [WORD_W-1:0] data;
    } wr_cmd_t;

    localparam logic [WORD_W-1:0] NO_VECTOR = '1;

    // Index of the lowest set bit, or all ones for an empty word.
    function automatic logic [WORD_W-1:0] lowest_set(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        r = NO_VECTOR;
        for (int k = WORD_W - 1; k >= 0; k--) begin
            if (v[k]) r = WORD_W'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture
    import irqc_pkg::*;
#(
    parameter int                NUM_SRC   = 32,
    parameter logic [WORD_W-1:0] EDGE_MASK = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               ack_we,
    input  logic [NUM_SRC-1:0] ack_mask,
    output logic [NUM_SRC-1:0] status
);

    localparam logic [NUM_SRC-1:0] EDGE_SEL = EDGE_MASK[NUM_SRC-1:0];

    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] hit;
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] clr;

    assign clr    = ack_we ? ack_mask : '0;
    assign status = stat_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (EDGE_SEL[i]) begin : g_edge
            assign hit[i] = src_in[i] & ~prev_q[i];

            assert_edge_only_R3: assert property (@(posedge clk) disable iff (rst)
                (!stat_q[i] && !(src_in[i] && !prev_q[i])) |=> !stat_q[i]);
        end else begin : g_level
            assign hit[i] = src_in[i];

            assert_level_sets_R2: assert property (@(posedge clk) disable iff (rst)
                src_in[i] |=> stat_q[i]);
        end

        assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
            (ack_we && ack_mask[i] && !src_in[i]) |=> !stat_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= src_in;
            stat_q <= (stat_q & ~clr) | hit;
        end
    end

endmodule

// File: rtl/irqc_enable.sv
module irqc_enable
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_cmd_t            cmd,
    output logic [NUM_SRC-1:0] enable,
    output mer_t               mer
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] mask;
    mer_t               mer_q;

    assign mask   = cmd.data[NUM_SRC-1:0];
    assign enable = en_q;
    assign mer    = mer_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            mer_q <= '0;
        end else begin
            if (cmd.en_ld)       en_q <= mask;
            else if (cmd.en_set) en_q <= en_q | mask;
            else if (cmd.en_clr) en_q <= en_q & ~mask;
            if (cmd.mer_ld)      mer_q <= mer_t'(cmd.data[1:0]);
        end
    end

    assert_set_or_R5: assert property (@(posedge clk) disable iff (rst)
        cmd.en_set |=> ((en_q & $past(mask)) == $past(mask)));

    assert_clr_bits_R5: assert property (@(posedge clk) disable iff (rst)
        cmd.en_clr |=> ((en_q & $past(mask)) == '0));

    assert_set_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        cmd.en_set |=> ((en_q & $past(en_q)) == $past(en_q)));

endmodule

// File: rtl/irqc_vector.sv
module irqc_vector
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend_in,
    output logic [WORD_W-1:0]  vec_out
);

    logic [WORD_W-1:0] pend_w;

    always_comb begin
        pend_w = '0;
        pend_w[NUM_SRC-1:0] = pend_in;
    end

    assign vec_out = lowest_set(pend_w);

    assert_vec_empty_R7: assert property (@(posedge clk) disable iff (rst)
        (vec_out == NO_VECTOR) |-> (pend_in == '0));

    assert_vec_valid_R7: assert property (@(posedge clk) disable iff (rst)
        (vec_out != NO_VECTOR) |->
            (pend_w[vec_out[4:0]] &&
             ((pend_w & ((32'd1 << vec_out[4:0]) - 32'd1)) == '0)));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int                NUM_SRC   = 32,
    parameter logic [WORD_W-1:0] EDGE_MASK = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               irq_out
);

    reg_sel_e           sel;
    wr_cmd_t            cmd;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] enable;
    logic [NUM_SRC-1:0] pend;
    mer_t               mer;
    logic [WORD_W-1:0]  vec;
    logic [WORD_W-1:0]  stat_w, en_w, pend_w;

    assign sel = reg_sel_e'(bus_addr[4:2]);

    always_comb begin
        cmd        = '0;
        cmd.data   = bus_wdata;
        cmd.ack    = bus_wr && (sel == SEL_ACK);
        cmd.en_ld  = bus_wr && (sel == SEL_EN);
        cmd.en_set = bus_wr && (sel == SEL_SETEN);
        cmd.en_clr = bus_wr && (sel == SEL_CLREN);
        cmd.mer_ld = bus_wr && (sel == SEL_MER);
    end

    irqc_capture #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .src_in   (src_in),
        .ack_we   (cmd.ack),
        .ack_mask (bus_wdata[NUM_SRC-1:0]),
        .status   (status)
    );

    irqc_enable #(.NUM_SRC(NUM_SRC)) u_en (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .enable (enable),
        .mer    (mer)
    );

    assign pend = status & enable;

    irqc_vector #(.NUM_SRC(NUM_SRC)) u_vec (
        .clk     (clk),
        .rst     (rst),
        .pend_in (pend),
        .vec_out (vec)
    );

    always_comb begin
        stat_w = '0;
        en_w   = '0;
        pend_w = '0;
        stat_w[NUM_SRC-1:0] = status;
        en_w[NUM_SRC-1:0]   = enable;
        pend_w[NUM_SRC-1:0] = pend;
    end

    always_comb begin
        unique case (sel)
            SEL_STAT: bus_rdata = stat_w;
            SEL_PEND: bus_rdata = pend_w;
            SEL_EN:   bus_rdata = en_w;
            SEL_VEC:  bus_rdata = vec;
            SEL_MER:  bus_rdata = {30'd0, mer};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_out = mer.glb_en && mer.req_en && (pend != '0);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (mer == 2'b11 && status != '0 && enable != '0));

    assert_irq_fires_R8: assert property (@(posedge clk) disable iff (rst)
        (mer == 2'b11 && (status & enable) != '0) |-> irq_out);

endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 8;

    localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_EN = 5'h08, A_ACK = 5'h0C,
                           A_SET = 5'h10, A_CLR = 5'h14, A_VEC = 5'h18, A_MER = 5'h1C;

    // {enable write, source pulse, expected status, expected pending, expected vector}
    typedef struct packed {
        logic [31:0] en;
        logic [7:0]  src;
        logic [31:0] st;
        logic [31:0] pd;
        logic [31:0] vc;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{32'hFF,       8'h01, 32'h01, 32'h01, 32'd0},
        '{32'hFF,       8'h80, 32'h80, 32'h80, 32'd7},
        '{32'hFF,       8'h90, 32'h90, 32'h90, 32'd4},
        '{32'h0F,       8'hF0, 32'hF0, 32'h00, 32'hFFFF_FFFF},
        '{32'hF0,       8'h3C, 32'h3C, 32'h30, 32'd4},
        '{32'hFF,       8'h00, 32'h00, 32'h00, 32'hFFFF_FFFF},
        '{32'h06,       8'hFF, 32'hFF, 32'h06, 32'd1},
        '{32'hFFFF_FFFF,8'h0C, 32'h0C, 32'h0C, 32'd2}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_in = '0;
    logic            bus_wr = 1'b0;
    logic [4:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top #(.NUM_SRC(NSRC), .EDGE_MASK(32'hFFFF_FFF0)) u0 (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        rd_chk("R1 status", A_STAT, 32'h0);
        rd_chk("R1 enable", A_EN, 32'h0);
        rd_chk("R1 master", A_MER, 32'h0);
        chk("R1 irq", {31'd0, irq_out}, 32'h0);
        rd_chk("R1 ack read", A_ACK, 32'h0);
        rd_chk("R1 set read", A_SET, 32'h0);
        rd_chk("R1 clr read", A_CLR, 32'h0);
        rd_chk("R7 vector empty", A_VEC, 32'hFFFF_FFFF);

        // Table walk: R6 pending, R7 vector, R9 upper enable bits
        for (int k = 0; k < NV; k++) begin
            wr(A_ACK, 32'hFFFF_FFFF);
            wr(A_EN, TBL[k].en);
            src_in = TBL[k].src;
            tick();
            src_in = '0;
            tick();
            rd_chk("R6 status", A_STAT, TBL[k].st);
            rd_chk("R6 pending", A_PEND, TBL[k].pd);
            rd_chk("R7 vector", A_VEC, TBL[k].vc);
            rd_chk("R9 enable width", A_EN, TBL[k].en & 32'hFF);
        end

        // R5 set / clear / zero
        wr(A_ACK, 32'hFFFF_FFFF);
        wr(A_EN, 32'h0F);
        wr(A_SET, 32'h30);
        rd_chk("R5 set-or", A_EN, 32'h3F);
        wr(A_CLR, 32'h05);
        rd_chk("R5 clear", A_EN, 32'h3A);
        wr(A_EN, 32'h0);
        rd_chk("R5 zero disables", A_EN, 32'h0);

        // R2 level re-set while held
        wr(A_EN, 32'hFF);
        src_in = 8'h01;
        tick();
        wr(A_ACK, 32'h01);
        rd_chk("R2 level held", A_STAT, 32'h01);
        src_in = 8'h00;
        tick();
        wr(A_ACK, 32'h01);
        rd_chk("R2 level released", A_STAT, 32'h0);

        // R3 edge held high
        src_in = 8'h10;
        tick();
        rd_chk("R3 edge latched", A_STAT, 32'h10);
        wr(A_ACK, 32'h10);
        tick();
        rd_chk("R3 edge held no reset", A_STAT, 32'h0);
        src_in = 8'h00;
        tick();

        // R4 selective acknowledge
        src_in = 8'h11;
        tick();
        src_in = 8'h00;
        tick();
        wr(A_ACK, 32'h01);
        rd_chk("R4 selective", A_STAT, 32'h10);
        wr(A_ACK, 32'hFFFF_FFFF);
        rd_chk("R4 all", A_STAT, 32'h0);

        // R8 master gate
        wr(A_EN, 32'h01);
        src_in = 8'h01;
        tick();
        src_in = 8'h00;
        wr(A_MER, 32'h1);
        rd_chk("R8 mer readback 1", A_MER, 32'h1);
        chk("R8 irq one bit", {31'd0, irq_out}, 32'h0);
        wr(A_MER, 32'hFFFF_FFFF);
        rd_chk("R8 mer readback 3", A_MER, 32'h3);
        chk("R8 irq both bits", {31'd0, irq_out}, 32'h1);
        wr(A_MER, 32'h2);
        rd_chk("R8 mer readback 2", A_MER, 32'h2);
        chk("R8 irq hw only", {31'd0, irq_out}, 32'h0);
        wr(A_MER, 32'h3);
        wr(A_ACK, 32'h01);
        chk("R8 irq no pending", {31'd0, irq_out}, 32'h0);

        // R10 read-only offsets
        wr(A_EN, 32'hAA);
        wr(A_STAT, 32'hFF);
        wr(A_PEND, 32'hFF);
        wr(A_VEC, 32'h0);
        rd_chk("R10 status unchanged", A_STAT, 32'h0);
        rd_chk("R10 enable unchanged", A_EN, 32'hAA);
        rd_chk("R10 master unchanged", A_MER, 32'h3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule